// File: doc/BRIEF.md
# UART Interrupt Status and Control

This block collects the interrupt causes of a high-speed UART into one status word and combines them into a single interrupt request. It watches several sources. The receive FIFO supplies two live levels, one for the trigger and one for the timeout. The line receiver sends single-cycle pulses for framing error, break and overrun. The transmit FIFO supplies its current byte count, which the block compares against a programmed trigger level. Error, break, overrun and transmit-request causes are sticky. Software clears them by writing ones to the status word. The two receive causes are not stored: they follow the FIFO's own condition.

A control register holds three group enables: transmit, receive and error. It also holds a break-transmit bit that the line driver follows. The remaining fields configure the serial datapath: transmit trigger code, receive trigger code, inactivity timeout code and receive sample offset. The transmit trigger code is decoded here into a byte threshold. Both registers sit behind a simple 32-bit register port. Status is at byte offset 0x0 and control at offset 0x4. Reads are combinational and writes take effect at the clock edge.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the status word reads 0 (with both receive inputs low), the control word reads 0x0000_2800 (sample offset 20, everything else 0), and `irq` and `tx_break` are 0.
- R2: A pulse on `fe_evt`, `brk_evt` or `ovr_evt` sets status bit 3, 4 or 5 respectively at the next clock edge. The bit then stays set until it is cleared.
- R3: A write to the status offset clears each of bits 0, 3, 4 and 5 where the written bit is 1 and leaves the others unchanged. Writes have no effect on bits 1 and 2.
- R4: When a set event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Status bit 1 equals `rx_trig_in` and status bit 2 equals `rx_tmo_in` in the same cycle, without storage.
- R6: The transmit trigger code in control bits [1:0] decodes to a threshold of 0, 4, 8 or 16 bytes for codes 0 to 3, driven on `tx_lvl`. Status bit 0 is set at the edge where `tx_count` first becomes less than or equal to that threshold. Staying at or below the threshold does not set it again.
- R7: Writing 1 to status bit 6 sets status bit 0 at that edge. Bit 6 always reads 0.
- R8: Control fields [1:0], [4:2], 5, 6, 7, 8, [13:9] and [17:16] read back as written; all other control bits read 0. The receive trigger, timeout and offset fields are driven on their output ports.
- R9: `tx_break` equals control bit 8.
- R10: `irq` is 1 one cycle after any enabled cause is set. Transmit enable is control bit 5 and gates status bit 0. Receive enable is bit 6 and gates bits 1 and 2. Error enable is bit 7 and gates bits 3, 4 and 5.
- R11: `irq` returns to 0 one cycle after the last enabled cause is cleared or its enable is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| rx_trig_in | input | 1 | Receive FIFO at or above its trigger level (live) |
| rx_tmo_in | input | 1 | Receive inactivity timeout active (live) |
| fe_evt | input | 1 | Framing error pulse |
| brk_evt | input | 1 | Break received pulse |
| ovr_evt | input | 1 | Receive overrun pulse |
| tx_count | input | COUNT_W | Bytes currently in the transmit FIFO |
| tx_lvl | output | COUNT_W | Decoded transmit trigger threshold in bytes |
| rx_trig_code | output | 3 | Receive trigger code for the FIFO |
| tmo_code | output | 2 | Inactivity timeout code for the receiver |
| rx_offset | output | 5 | Receive sample offset |
| tx_break | output | 1 | Force the transmit line into break |
| irq | output | 1 | Registered interrupt request |

## Verification
Different results appear at different times. Status bits 1 and 2, and the read data for any stored value, change in the same cycle as their inputs. Stored status bits and control fields change at the first clock edge after the pulse or write. `irq` follows one edge later than the status or control change that causes it. The bench changes inputs on the falling edge. It reads the registers just after the next falling edge, which lies after the edge that stores them, and it waits one further full cycle before it checks `irq`. For the transmit threshold, the bench steps `tx_count` from above the level to just above it and then onto it. It checks that only the final step sets the request bit.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int REG_W = 32;

  // status bit positions (software decodes these)
  localparam int ST_TXREQ = 0;
  localparam int ST_RXTRG = 1;
  localparam int ST_RXTMO = 2;
  localparam int ST_FRERR = 3;
  localparam int ST_BRK   = 4;
  localparam int ST_OVR   = 5;
  localparam int ST_TXSET = 6;

  // control bit positions
  localparam int CT_TXEN  = 5;
  localparam int CT_RXEN  = 6;
  localparam int CT_ERREN = 7;
  localparam int CT_BREAK = 8;

  localparam logic [REG_W-1:0] CTRL_WMASK = 32'h0003_3FFF;
  localparam int               OFFSET_RST = 20;

  typedef struct packed {
    logic [1:0] tmo_code;
    logic [4:0] rx_offset;
    logic       brk;
    logic       en_err;
    logic       en_rx;
    logic       en_tx;
    logic [2:0] rx_trig;
    logic [1:0] tx_trig;
  } ctrl_t;

  // threshold in bytes for a transmit trigger code
  function automatic int unsigned tx_level_bytes(input logic [1:0] code);
    return (code == 2'd0) ? 0 : (32'd2 << code);
  endfunction

  // request from status bits and group enables
  function automatic logic cause_any(input logic [5:0] st, input logic en_tx,
                                     input logic en_rx, input logic en_err);
    return (en_tx  & st[ST_TXREQ]) |
           (en_rx  & (st[ST_RXTRG] | st[ST_RXTMO])) |
           (en_err & (st[ST_FRERR] | st[ST_BRK] | st[ST_OVR]));
  endfunction

  function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
    logic [REG_W-1:0] w;
    w        = '0;
    w[1:0]   = c.tx_trig;
    w[4:2]   = c.rx_trig;
    w[CT_TXEN]  = c.en_tx;
    w[CT_RXEN]  = c.en_rx;
    w[CT_ERREN] = c.en_err;
    w[CT_BREAK] = c.brk;
    w[13:9]  = c.rx_offset;
    w[17:16] = c.tmo_code;
    return w;
  endfunction

  function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.tx_trig   = w[1:0];
    c.rx_trig   = w[4:2];
    c.en_tx     = w[CT_TXEN];
    c.en_rx     = w[CT_RXEN];
    c.en_err    = w[CT_ERREN];
    c.brk       = w[CT_BREAK];
    c.rx_offset = w[13:9];
    c.tmo_code  = w[17:16];
    return c;
  endfunction

endpackage

// File: rtl/uis_ctrl_reg.sv
module uis_ctrl_reg
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic [REG_W-1:0] ctrl_word
);
  localparam ctrl_t CTRL_RST = '{tmo_code: 2'd0, rx_offset: 5'(OFFSET_RST),
                                 brk: 1'b0, en_err: 1'b0, en_rx: 1'b0,
                                 en_tx: 1'b0, rx_trig: 3'd0, tx_trig: 2'd0};

  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= CTRL_RST;
    else if (wr) ctrl_q <= ctrl_unpack(wdata & CTRL_WMASK);
  end

  assign ctrl      = ctrl_q;
  assign ctrl_word = ctrl_pack(ctrl_q);
endmodule

// File: rtl/uis_tx_watch.sv
module uis_tx_watch
  import uart_irq_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         code,
  input  logic [COUNT_W-1:0] count,
  output logic [COUNT_W-1:0] level,
  output logic               hit
);
  logic below, below_q;

  assign level = COUNT_W'(tx_level_bytes(code));
  assign below = (count <= level);

  // FIFO starts empty, so the comparison starts "already below"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) below_q <= 1'b1;
    else        below_q <= below;
  end

  assign hit = below & ~below_q;
endmodule

// File: rtl/uis_status.sv
module uis_status #(
  parameter int NLAT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLAT-1:0] set_v,
  input  logic [NLAT-1:0] clr_v,
  output logic [NLAT-1:0] lat_q
);
  for (genvar i = 0; i < NLAT; i++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q[i] <= 1'b0;
      else        lat_q[i] <= set_v[i] | (lat_q[i] & ~clr_v[i]);
    end
  end
endmodule

// File: rtl/uis_irq_gen.sv
module uis_irq_gen
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] st,
  input  logic       en_tx,
  input  logic       en_rx,
  input  logic       en_err,
  output logic       cause,
  output logic       irq
);
  assign cause = cause_any(st, en_tx, en_rx, en_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= cause;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter int              COUNT_W  = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h0,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               rx_trig_in,
  input  logic               rx_tmo_in,
  input  logic               fe_evt,
  input  logic               brk_evt,
  input  logic               ovr_evt,
  input  logic [COUNT_W-1:0] tx_count,
  output logic [COUNT_W-1:0] tx_lvl,
  output logic [2:0]         rx_trig_code,
  output logic [1:0]         tmo_code,
  output logic [4:0]         rx_offset,
  output logic               tx_break,
  output logic               irq
);
  localparam int NLAT = 4;  // latched bits 0,3,4,5

  ctrl_t            ctrl;
  logic [REG_W-1:0] ctrl_word;
  logic             wr_stat, wr_ctrl;
  logic             tx_hit;
  logic [NLAT-1:0]  set_v, clr_v, lat_q;
  logic [5:0]       stat_q;
  logic [REG_W-1:0] stat_word;
  logic             cause;

  assign wr_stat = reg_wr & (reg_addr == STAT_OFS);
  assign wr_ctrl = reg_wr & (reg_addr == CTRL_OFS);

  uis_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wdata(reg_wdata),
    .ctrl(ctrl), .ctrl_word(ctrl_word)
  );

  uis_tx_watch #(.COUNT_W(COUNT_W)) u_txw (
    .clk(clk), .rst_n(rst_n), .code(ctrl.tx_trig), .count(tx_count),
    .level(tx_lvl), .hit(tx_hit)
  );

  // latched order: {ovr, brk, fe, txreq}
  assign set_v = {ovr_evt, brk_evt, fe_evt, tx_hit | (wr_stat & reg_wdata[ST_TXSET])};
  assign clr_v = wr_stat ? {reg_wdata[ST_OVR], reg_wdata[ST_BRK],
                            reg_wdata[ST_FRERR], reg_wdata[ST_TXREQ]} : '0;

  uis_status #(.NLAT(NLAT)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .lat_q(lat_q)
  );

  assign stat_q    = {lat_q[3], lat_q[2], lat_q[1], rx_tmo_in, rx_trig_in, lat_q[0]};
  assign stat_word = {{(REG_W-6){1'b0}}, stat_q};

  uis_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .st(stat_q), .en_tx(ctrl.en_tx),
    .en_rx(ctrl.en_rx), .en_err(ctrl.en_err), .cause(cause), .irq(irq)
  );

  always_comb begin
    if (reg_addr == STAT_OFS)      reg_rdata = stat_word;
    else if (reg_addr == CTRL_OFS) reg_rdata = ctrl_word;
    else                           reg_rdata = '0;
  end

  assign rx_trig_code = ctrl.rx_trig;
  assign tmo_code     = ctrl.tmo_code;
  assign rx_offset    = ctrl.rx_offset;
  assign tx_break     = ctrl.brk;
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fe_evt,
  input logic       brk_evt,
  input logic       ovr_evt,
  input logic       wr_stat,
  input logic [31:0] reg_wdata,
  input logic [5:0] stat_q,
  input logic       cause,
  input logic       irq
);
  // R2
  fe_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_evt |=> stat_q[3]);
  // R2
  brk_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> stat_q[4]);
  // R2
  ovr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> stat_q[5]);
  // R3
  fe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[3] && !fe_evt) |=> !stat_q[3]);
  // R3
  fe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[3] && !(wr_stat && reg_wdata[3])) |=> stat_q[3]);
  // R7
  soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[6] && !reg_wdata[0]) |=> stat_q[0]);
  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> irq);
  // R11
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cause |=> !irq);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fe_evt(fe_evt), .brk_evt(brk_evt),
  .ovr_evt(ovr_evt), .wr_stat(wr_stat), .reg_wdata(reg_wdata),
  .stat_q(stat_q), .cause(cause), .irq(irq)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_ST = 4'h0;
  localparam logic [3:0] A_CT = 4'h4;

  logic        clk = 0, rst_n = 0;
  logic [3:0]  reg_addr = A_ST;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        rx_trig_in = 0, rx_tmo_in = 0, fe_evt = 0, brk_evt = 0, ovr_evt = 0;
  logic [7:0]  tx_count = 0, tx_lvl;
  logic [2:0]  rx_trig_code;
  logic [1:0]  tmo_code;
  logic [4:0]  rx_offset;
  logic        tx_break, irq;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_trig_in(rx_trig_in),
    .rx_tmo_in(rx_tmo_in), .fe_evt(fe_evt), .brk_evt(brk_evt), .ovr_evt(ovr_evt),
    .tx_count(tx_count), .tx_lvl(tx_lvl), .rx_trig_code(rx_trig_code),
    .tmo_code(tmo_code), .rx_offset(rx_offset), .tx_break(tx_break), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_ST, d); check("R1 status", d, 0);
    rd(A_CT, d); check("R1 control", d, 32'h2800);
    check("R1 irq", irq, 0);
    check("R1 tx_break", tx_break, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(A_CT, 32'hFFFF_FFFF);
    rd(A_CT, d); check("R8 readback mask", d, 32'h0003_3FFF);
    check("R8 rx_trig_code", rx_trig_code, 7);
    check("R8 tmo_code", tmo_code, 3);
    check("R8 rx_offset", rx_offset, 31);
    check("R6 level code3", tx_lvl, 16);
    check("R9 break on", tx_break, 1);
    wr(A_CT, 32'h1);  check("R6 level code1", tx_lvl, 4);
    wr(A_CT, 32'h2);  check("R6 level code2", tx_lvl, 8);
    wr(A_CT, 32'h0);  check("R6 level code0", tx_lvl, 0);
    check("R9 break off", tx_break, 0);
    rd(A_ST, d); check("R6 no request after level change", d[0], 0);
  endtask

  task automatic t_errors();
    logic [31:0] d;
    @(negedge clk); fe_evt = 1; @(negedge clk); fe_evt = 0;
    rd(A_ST, d); check("R2 framing latched", d, 32'h08);
    cyc(1); check("R10 masked irq", irq, 0);
    wr(A_CT, 32'h80); cyc(1);
    check("R10 error irq", irq, 1);
    wr(A_ST, 32'h10);
    rd(A_ST, d); check("R3 zero leaves bit3", d, 32'h08);
    wr(A_ST, 32'h08);
    rd(A_ST, d); check("R3 clear bit3", d, 0);
    cyc(1); check("R11 irq drop", irq, 0);
    @(negedge clk); brk_evt = 1; ovr_evt = 1; @(negedge clk); brk_evt = 0; ovr_evt = 0;
    rd(A_ST, d); check("R2 break+overrun", d, 32'h30);
    wr(A_ST, 32'h20);
    rd(A_ST, d); check("R3 clear overrun only", d, 32'h10);
    wr(A_CT, 32'h0); cyc(1);
    check("R11 enable removed", irq, 0);
    wr(A_ST, 32'h10);
    // R4 same-cycle set and clear
    @(negedge clk); reg_addr = A_ST; reg_wdata = 32'h08; reg_wr = 1; fe_evt = 1;
    @(negedge clk); reg_wr = 0; fe_evt = 0;
    rd(A_ST, d); check("R4 set wins", d, 32'h08);
    wr(A_ST, 32'h08);
  endtask

  task automatic t_live();
    logic [31:0] d;
    wr(A_CT, 32'h40);
    @(negedge clk); rx_trig_in = 1;
    rd(A_ST, d); check("R5 trigger live", d, 32'h02);
    cyc(1); check("R10 rx irq", irq, 1);
    wr(A_ST, 32'h06);
    rd(A_ST, d); check("R3 live bits unaffected", d, 32'h02);
    @(negedge clk); rx_trig_in = 0; rx_tmo_in = 1;
    rd(A_ST, d); check("R5 timeout live", d, 32'h04);
    @(negedge clk); rx_tmo_in = 0;
    rd(A_ST, d); check("R5 both low", d, 0);
    cyc(1); check("R11 rx irq drop", irq, 0);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    wr(A_CT, 32'h21);
    @(negedge clk); tx_count = 10;
    @(negedge clk); tx_count = 5;
    @(negedge clk);
    rd(A_ST, d); check("R6 above level no request", d[0], 0);
    tx_count = 4;
    @(negedge clk);
    rd(A_ST, d); check("R6 crossing sets request", d[0], 1);
    cyc(1); check("R10 tx irq", irq, 1);
    wr(A_ST, 32'h01);
    rd(A_ST, d); check("R6 no re-set while below", d[0], 0);
    cyc(1); check("R11 tx irq drop", irq, 0);
    wr(A_ST, 32'h40);
    rd(A_ST, d); check("R7 soft set", d, 32'h01);
    wr(A_ST, 32'h01);
    tx_count = 0;
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 20000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
      begin
        cyc(3); rst_n = 1; cyc(1);
        t_reset();
        t_ctrl();
        t_errors();
        t_live();
        t_tx();
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule